// File: doc/BRIEF.md
# Power-Management Command Port with SMI Request Latch

This block sits behind the byte-wide power-management command port of a chipset. Software writes one command byte at a time. Two reserved codes switch the platform's ACPI mode flag on or off, and they never request system management mode. Any other code is treated as a request for the system management handler. It raises a system management interrupt (SMI) request, but only when an enable bit in a small configuration byte bank allows it. The request is a level. It stays high until the handler acknowledges it with a one-cycle clear strobe.

The configuration bank holds four bytes, written and read through a byte port. The byte at offset 3 is the SMI control byte, and its bit 1 is the SMI enable. A build parameter states whether the platform supports system management mode. When it does not, the SMI control byte comes out of reset as 0x02. That value marks the handler as already initialised, so any other command raises an SMI straight away. The last command byte written can always be read back on the command port.

All outputs are registered. A command written in one cycle affects acpi_en, smi_req and cmd_rd_data from the next clock edge.

Top module: `apm_cmd_port`

## Requirements
- R1: A command write of 0xF1 sets acpi_en from the next clock edge. It does not set smi_req.
- R2: A command write of 0xF0 clears acpi_en from the next clock edge. It does not set smi_req, whatever the enable bit holds.
- R3: A command write of any code other than 0xF0 or 0xF1 sets smi_req from the next edge, provided bit 1 of configuration byte 3 is 1. If that bit is 0, smi_req keeps its previous value.
- R4: Once set, smi_req stays high until a cycle with smi_clr high, and it is low from the edge after that cycle. When a trigger and smi_clr arrive in the same cycle, smi_req stays high.
- R5: Synchronous reset clears acpi_en, smi_req, cmd_rd_data and cfg_rd_data, and sets configuration bytes 0 to 3 to 0x00. With SMM_SUPPORTED = 0, byte 3 resets to 0x02 instead.
- R6: A configuration write with cfg_wr_en takes effect at the clock edge. cfg_rd_data shows the byte at cfg_rd_addr as it was before that edge, so it has one cycle of latency. A command written in the same cycle as a write to byte 3 is judged against the old enable bit.
- R7: From the edge after any command write, cmd_rd_data returns the written byte. This includes 0xF0 and 0xF1.
- R8: A write of 0xF1 while acpi_en is already 1, or of 0xF0 while it is already 0, leaves acpi_en and smi_req unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_en | input | 1 | Command byte write strobe |
| cmd_wr_data | input | 8 | Command byte |
| cmd_rd_data | output | 8 | Last command byte written |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_addr | input | 2 | Configuration byte offset for writes |
| cfg_wr_data | input | 8 | Configuration byte write data |
| cfg_rd_addr | input | 2 | Configuration byte offset for reads |
| cfg_rd_data | output | 8 | Registered configuration read data |
| smi_clr | input | 1 | One-cycle SMI acknowledge |
| smi_req | output | 1 | SMI request level |
| acpi_en | output | 1 | ACPI mode flag |

## Verification
The two mode codes are written while the enable bit is set and while it is clear. This shows that they cannot raise an SMI under either setting, where an ordinary code does raise one. Repeating a mode code that is already in effect shows that a redundant write does nothing. Two cases target the latch: clearing while a trigger arrives in the same cycle, and writing byte 3 while a command is written in the same cycle. These separate trigger priority from clear priority, and the old enable bit from the new one. A long pseudo-random stretch mixes every input, and a second instance built without SMM support shows the 0x02 reset value taking effect.

// File: rtl/apm_pkg.sv
package apm_pkg;
  typedef enum logic [1:0] {
    KIND_MODE_ON  = 2'd0,
    KIND_MODE_OFF = 2'd1,
    KIND_SERVICE  = 2'd2
  } cmd_kind_t;
endpackage

// File: rtl/apm_cfg_bank.sv
module apm_cfg_bank #(
  parameter int BYTE_W        = 8,
  parameter int NBYTES        = 4,
  parameter int CTRL_IDX      = 3,
  parameter int EN_BIT        = 1,
  parameter bit SMM_SUPPORTED = 1'b1,
  localparam int AW           = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              smi_allowed
);
  localparam logic [BYTE_W-1:0] CTRL_RST =
    SMM_SUPPORTED ? '0 : BYTE_W'(1 << EN_BIT);

  logic [BYTE_W-1:0] bank [NBYTES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBYTES; i++)
        bank[i] <= (i == CTRL_IDX) ? CTRL_RST : '0;
      rd_data <= '0;
    end else begin
      rd_data <= bank[rd_addr];
      if (wr_en) bank[wr_addr] <= wr_data;
    end
  end

  assign smi_allowed = bank[CTRL_IDX][EN_BIT];

  // R6
  ctrl_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(CTRL_IDX)) |=> (smi_allowed == $past(wr_data[EN_BIT])));
endmodule

// File: rtl/apm_cmd_decode.sv
module apm_cmd_decode
  import apm_pkg::*;
#(
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] CODE_ON  = 8'hF1,
  parameter logic [DATA_W-1:0] CODE_OFF = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              smi_allowed,
  output logic [DATA_W-1:0] last_cmd,
  output logic              mode_q,
  output logic              trigger
);
  cmd_kind_t kind;

  always_comb begin
    if (wr_data == CODE_ON)       kind = KIND_MODE_ON;
    else if (wr_data == CODE_OFF) kind = KIND_MODE_OFF;
    else                          kind = KIND_SERVICE;
  end

  assign trigger = wr_en && (kind == KIND_SERVICE) && smi_allowed;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_cmd <= '0;
      mode_q   <= 1'b0;
    end else if (wr_en) begin
      last_cmd <= wr_data;
      if (kind == KIND_MODE_ON)       mode_q <= 1'b1;
      else if (kind == KIND_MODE_OFF) mode_q <= 1'b0;
    end
  end

  // R1
  mode_on_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data == CODE_ON) |=> mode_q);
  // R2
  mode_off_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data == CODE_OFF) |=> !mode_q);
  // R7
  readback_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (last_cmd == $past(wr_data)));
endmodule

// File: rtl/apm_smi_latch.sv
module apm_smi_latch (
  input  logic clk,
  input  logic rst,
  input  logic trigger,
  input  logic clear,
  output logic smi_q
);
  always_ff @(posedge clk) begin
    if (rst)          smi_q <= 1'b0;
    else if (trigger) smi_q <= 1'b1;
    else if (clear)   smi_q <= 1'b0;
  end

  // R4
  smi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (smi_q && !clear) |=> smi_q);
  // R4
  smi_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clear && !trigger) |=> !smi_q);
  // R3
  smi_set_chk: assert property (@(posedge clk) disable iff (rst)
    trigger |=> smi_q);
endmodule

// File: rtl/apm_cmd_port.sv
module apm_cmd_port #(
  parameter int DATA_W        = 8,
  parameter int CFG_BYTES     = 4,
  parameter int CTRL_IDX      = 3,
  parameter int SMI_EN_BIT    = 1,
  parameter bit SMM_SUPPORTED = 1'b1,
  localparam int CAW          = $clog2(CFG_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr_en,
  input  logic [DATA_W-1:0] cmd_wr_data,
  output logic [DATA_W-1:0] cmd_rd_data,
  input  logic              cfg_wr_en,
  input  logic [CAW-1:0]    cfg_wr_addr,
  input  logic [DATA_W-1:0] cfg_wr_data,
  input  logic [CAW-1:0]    cfg_rd_addr,
  output logic [DATA_W-1:0] cfg_rd_data,
  input  logic              smi_clr,
  output logic              smi_req,
  output logic              acpi_en
);
  localparam logic [DATA_W-1:0] CODE_ON  = DATA_W'(8'hF1);
  localparam logic [DATA_W-1:0] CODE_OFF = DATA_W'(8'hF0);

  logic smi_allowed;
  logic trigger;

  apm_cfg_bank #(
    .BYTE_W(DATA_W), .NBYTES(CFG_BYTES), .CTRL_IDX(CTRL_IDX),
    .EN_BIT(SMI_EN_BIT), .SMM_SUPPORTED(SMM_SUPPORTED)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
    .wr_data(cfg_wr_data), .rd_addr(cfg_rd_addr), .rd_data(cfg_rd_data),
    .smi_allowed(smi_allowed)
  );

  apm_cmd_decode #(
    .DATA_W(DATA_W), .CODE_ON(CODE_ON), .CODE_OFF(CODE_OFF)
  ) u_dec (
    .clk(clk), .rst(rst), .wr_en(cmd_wr_en), .wr_data(cmd_wr_data),
    .smi_allowed(smi_allowed), .last_cmd(cmd_rd_data), .mode_q(acpi_en),
    .trigger(trigger)
  );

  apm_smi_latch u_smi (
    .clk(clk), .rst(rst), .trigger(trigger), .clear(smi_clr), .smi_q(smi_req)
  );

  // R2
  mode_code_no_smi_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr_en && (cmd_wr_data == CODE_ON || cmd_wr_data == CODE_OFF) && !smi_req)
      |=> !smi_req);
  // R8
  redundant_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr_en && cmd_wr_data == CODE_ON && acpi_en && !smi_clr) |=> ($stable(acpi_en) && $stable(smi_req)));
endmodule

// File: tb/sim_apm_cmd_port.sv
module sim_apm_cmd_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic       cmd_wr_en = 0;
  logic [7:0] cmd_wr_data = 0;
  logic       cfg_wr_en = 0;
  logic [1:0] cfg_wr_addr = 0;
  logic [7:0] cfg_wr_data = 0;
  logic [1:0] cfg_rd_addr = 0;
  logic       smi_clr = 0;

  logic [7:0] a_cmd [2];
  logic [7:0] a_cfg [2];
  logic       a_smi [2];
  logic       a_acpi [2];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  apm_cmd_port u0 (
    .clk(clk), .rst(rst), .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
    .cmd_rd_data(a_cmd[0]), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(a_cfg[0]),
    .smi_clr(smi_clr), .smi_req(a_smi[0]), .acpi_en(a_acpi[0])
  );

  apm_cmd_port #(.SMM_SUPPORTED(1'b0)) u1 (
    .clk(clk), .rst(rst), .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
    .cmd_rd_data(a_cmd[1]), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(a_cfg[1]),
    .smi_clr(smi_clr), .smi_req(a_smi[1]), .acpi_en(a_acpi[1])
  );

  // behavioural reference state, one set per instance
  int m_cmd [2];
  int m_acpi [2];
  int m_smi [2];
  int m_rd [2];
  int m_cfg [2][4];

  task automatic check(input string tag, input string what, input int k,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s inst%0d actual=%0h expected=%0h", tag, what, k, act, exp);
    end
  endtask

  task automatic model_edge();
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        m_cmd[k] = 0; m_acpi[k] = 0; m_smi[k] = 0; m_rd[k] = 0;
        for (int i = 0; i < 4; i++) m_cfg[k][i] = 0;
        if (k == 1) m_cfg[k][3] = 2;
      end else begin
        bit allowed = m_cfg[k][3][1];
        bit trig = 0;
        if (cmd_wr_en) begin
          m_cmd[k] = cmd_wr_data;
          if (cmd_wr_data == 8'hF1) m_acpi[k] = 1;
          else if (cmd_wr_data == 8'hF0) m_acpi[k] = 0;
          else trig = allowed;
        end
        if (trig) m_smi[k] = 1;
        else if (smi_clr) m_smi[k] = 0;
        m_rd[k] = m_cfg[k][cfg_rd_addr];
        if (cfg_wr_en) m_cfg[k][cfg_wr_addr] = cfg_wr_data;
      end
    end
  endtask

  task automatic compare_all();
    for (int k = 0; k < 2; k++) begin
      check("R1/R2/R8", "acpi_en", k, a_acpi[k], m_acpi[k]);
      check("R3/R4", "smi_req", k, a_smi[k], m_smi[k]);
      check("R6", "cfg_rd_data", k, a_cfg[k], m_rd[k]);
      check("R7", "cmd_rd_data", k, a_cmd[k], m_cmd[k]);
    end
  endtask

  // called at a falling edge with inputs already set
  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    cmd_wr_en = 0; cfg_wr_en = 0; smi_clr = 0;
  endtask

  task automatic cmd(input logic [7:0] v);
    idle(); cmd_wr_en = 1; cmd_wr_data = v; tick(); idle();
  endtask

  task automatic cfgw(input logic [1:0] a, input logic [7:0] v);
    idle(); cfg_wr_en = 1; cfg_wr_addr = a; cfg_wr_data = v; tick(); idle();
  endtask

  task automatic clr();
    idle(); smi_clr = 1; tick(); idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    @(negedge clk);
    rst = 1; tick(); tick();
    rst = 0;
    // R5: reset state, then sweep the read port over all bytes
    check("R5", "acpi_en rst", 0, a_acpi[0], 0);
    check("R5", "smi_req rst", 0, a_smi[0], 0);
    check("R5", "cmd_rd rst", 0, a_cmd[0], 0);
    for (int a = 0; a < 4; a++) begin
      idle(); cfg_rd_addr = 2'(a); tick();
    end
    idle(); tick();
    check("R5", "byte3 rst u1", 1, a_cfg[1], 8'h02);
    check("R5", "byte3 rst u0", 0, a_cfg[0], 8'h00);

    // R1, R2, R8 with enable clear on u0, set on u1
    cmd(8'hF1); check("R1", "acpi on", 0, a_acpi[0], 1);
    check("R1", "no smi on F1", 1, a_smi[1], 0);
    cmd(8'hF1); check("R8", "redundant on", 0, a_acpi[0], 1);
    cmd(8'hF0); check("R2", "acpi off", 0, a_acpi[0], 0);
    check("R2", "no smi on F0", 1, a_smi[1], 0);
    cmd(8'hF0); check("R8", "redundant off", 0, a_acpi[0], 0);
    // R3: service code, enable clear (u0) vs set (u1)
    cmd(8'hB2);
    check("R3", "smi gated", 0, a_smi[0], 0);
    check("R3", "smi raised", 1, a_smi[1], 1);
    check("R7", "readback", 0, a_cmd[0], 8'hB2);
    // R4: hold then clear
    idle(); tick(); tick();
    check("R4", "smi held", 1, a_smi[1], 1);
    clr(); check("R4", "smi cleared", 1, a_smi[1], 0);
    // R6: enable on u0, same-cycle command uses old bit
    idle(); cfg_wr_en = 1; cfg_wr_addr = 3; cfg_wr_data = 8'h02;
    cmd_wr_en = 1; cmd_wr_data = 8'h55; tick(); idle();
    check("R6", "old enable used", 0, a_smi[0], 0);
    cmd(8'h55); check("R3", "smi after enable", 0, a_smi[0], 1);
    // R4: trigger and clear together, trigger wins
    idle(); smi_clr = 1; cmd_wr_en = 1; cmd_wr_data = 8'h10; tick(); idle();
    check("R4", "trigger wins", 0, a_smi[0], 1);
    clr(); check("R4", "clear after", 0, a_smi[0], 0);
    // R2 with enable set, while latch low
    cmd(8'hF0); check("R2", "F0 no smi enabled", 0, a_smi[0], 0);
    cmd(8'hF1); check("R1", "F1 no smi enabled", 0, a_smi[0], 0);
    // R6 readback of written byte
    cfgw(2'd1, 8'h5A); idle(); cfg_rd_addr = 1; tick(); idle(); tick();
    check("R6", "cfg readback", 0, a_cfg[0], 8'h5A);

    // pseudo-random mix, compared on every clock
    for (int n = 0; n < 2000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cmd_wr_en = lf[0];
      case (lf[3:2])
        2'd0: cmd_wr_data = 8'hF0;
        2'd1: cmd_wr_data = 8'hF1;
        default: cmd_wr_data = lf[15:8];
      endcase
      cfg_wr_en = lf[4] & lf[5] & lf[6];
      cfg_wr_addr = lf[8:7];
      cfg_wr_data = lf[15:8];
      cfg_rd_addr = lf[10:9];
      smi_clr = lf[11] & lf[12];
      tick();
    end
    idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule